// File: doc/BRIEF.md
# Unaligned Byte-to-Word Write Packer

This block sits between a byte-oriented write client and a flash word programmer. A client starts a transfer with a byte start address and a byte length, then streams the payload bytes over a valid/ready interface. The packer turns the stream into a series of 32-bit program requests. Each request goes to a word-aligned address and carries four byte lanes.

Flash programming can only clear bits, so every lane that carries no payload is filled with 0xFF and leaves those cells unchanged. A start address that is not aligned produces a padded head word. A byte count that ends inside a word produces a padded tail word. All words in between are whole.

The programmer answers each request with a done or a fail pulse. A running count of committed payload bytes is updated after every word that succeeds. The first failure ends the transfer with an error flag.

Top module: `wpack_top`

## Requirements
- R1: Every program request carries an address whose two low bits are zero.
- R2: With an unaligned start, the first request goes to the start address rounded down to a multiple of 4. Lanes below the start offset (start address modulo 4) hold 0xFF.
- R3: If the payload ends inside the head word before lane 3, the lanes above the last payload byte hold 0xFF.
- R4: Whole 4-byte groups are issued as full words, each at the previous request's address plus 4.
- R5: When 1 to 3 payload bytes remain after the last whole group, they form a final word in lanes 0 upward, and the unused upper lanes hold 0xFF.
- R6: A start with length 0 raises `done` in the next cycle, issues no request and accepts no byte.
- R7: `byte_count` is cleared at start. It increases by the number of payload bytes in a word (padding excluded) in the cycle after that word's `wr_done`, and changes at no other time.
- R8: A `wr_fail` ends the transfer: `done` and `err` rise in the next cycle, no further request is issued, and the failed word's bytes are not counted.
- R9: Byte lane k occupies bits 8k+7:8k of `wr_data`, so lane 0 is bits 7:0 (little-endian).
- R10: `wr_req` stays high with stable `wr_addr` and `wr_data` until `wr_done` or `wr_fail`. `in_ready` is never high while `wr_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transfer; taken only while `busy` is low |
| start_addr | input | ADDR_W | Byte address of the first payload byte |
| length | input | LEN_W | Number of payload bytes |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| err | output | 1 | Last transfer ended on a failed word; held until the next start |
| byte_count | output | LEN_W | Payload bytes committed so far |
| in_valid | input | 1 | Payload byte valid |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | Packer takes the byte this cycle |
| wr_req | output | 1 | Word program request |
| wr_addr | output | ADDR_W | Aligned word byte address |
| wr_data | output | 32 | Word to program, padded with 0xFF |
| wr_done | input | 1 | Programmer finished the word successfully |
| wr_fail | input | 1 | Programmer reported a failure for the word |

## Verification
The assertions check four rules on every cycle: the word alignment of requests, request hold and stability, the exclusion between taking bytes and requesting, and the rule that the byte count moves only on a successful word. They also check the one-cycle reactions to a zero-length start and to a failure. Only the bench scenarios can show the lane contents. These are head padding below the offset, a head that runs out early, the tail padding and the little-endian order. The scenarios also show the exact committed count when a failure hits the first word or a later one.

// File: rtl/wpack_pkg.sv
// Package: shared constants and the state type of the write packer.
// Assumes a flash whose erased value is all ones, so 0xFF leaves bits untouched.
package wpack_pkg;
    localparam int WORD_BYTES = 4;
    localparam logic [7:0] FILL_BYTE = 8'hFF;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FILL  = 2'd1,
        S_ISSUE = 2'd2,
        S_DONE  = 2'd3
    } pk_state_t;
endpackage

// File: rtl/wpack_lane_buf.sv
// Module: word assembly buffer of byte lanes.
// Each lane is reloaded with the fill byte on preset, or takes the input
// byte when it is the selected lane. Assumes preset and write are never
// requested in the same cycle.
module wpack_lane_buf
    import wpack_pkg::*;
#(
    parameter int NLANES = WORD_BYTES,
    localparam int LANE_W = $clog2(NLANES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  preset,
    input  logic                  wr_en,
    input  logic [LANE_W-1:0]     lane,
    input  logic [7:0]            din,
    output logic [NLANES*8-1:0]   word
);
    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        // hold one byte lane: fill value, or the payload byte aimed at it
        always_ff @(posedge clk) begin
            if (!rst_n || preset) begin
                word[g*8 +: 8] <= FILL_BYTE;
            end else if (wr_en && lane == LANE_W'(g)) begin
                word[g*8 +: 8] <= din;
            end
        end
    end
endmodule

// File: rtl/wpack_ctrl.sv
// Module: transfer sequencer of the write packer.
// Tracks the aligned word address, the next lane, the remaining payload and
// the committed byte count. Moves between taking bytes, waiting for the
// programmer, and finishing. Assumes wr_done and wr_fail are pulses that
// answer a held request.
module wpack_ctrl
    import wpack_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LEN_W  = 16,
    localparam int LANE_W = $clog2(WORD_BYTES),
    localparam int NB_W   = $clog2(WORD_BYTES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [ADDR_W-1:0]  start_addr,
    input  logic [LEN_W-1:0]   length,
    input  logic               in_valid,
    input  logic               wr_done,
    input  logic               wr_fail,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic [LEN_W-1:0]   byte_count,
    output logic               in_ready,
    output logic               wr_req,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic               buf_preset,
    output logic               buf_we,
    output logic [LANE_W-1:0]  buf_lane
);
    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(WORD_BYTES - 1);

    pk_state_t          state;
    logic [ADDR_W-1:0]  waddr;
    logic [LANE_W-1:0]  lane;
    logic [LEN_W-1:0]   remain;
    logic [NB_W-1:0]    nbytes;
    logic [LEN_W-1:0]   count;
    logic               err_q;

    logic take, accept_start, word_full, more_after;

    // decode handshakes of the current cycle
    always_comb begin
        accept_start = (state == S_IDLE) && start;
        take         = (state == S_FILL) && in_valid;
        word_full    = (lane == LAST_LANE) || (remain == LEN_W'(1));
        more_after   = (remain != '0);
    end

    // sequencer state, address, lane, payload and count registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            waddr  <= '0;
            lane   <= '0;
            remain <= '0;
            nbytes <= '0;
            count  <= '0;
            err_q  <= 1'b0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (start) begin
                        waddr  <= {start_addr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
                        lane   <= start_addr[LANE_W-1:0];
                        remain <= length;
                        nbytes <= '0;
                        count  <= '0;
                        err_q  <= 1'b0;
                        state  <= (length == '0) ? S_DONE : S_FILL;
                    end
                end
                S_FILL: begin
                    if (in_valid) begin
                        lane   <= lane + LANE_W'(1);
                        remain <= remain - LEN_W'(1);
                        nbytes <= nbytes + NB_W'(1);
                        if (word_full) state <= S_ISSUE;
                    end
                end
                S_ISSUE: begin
                    if (wr_fail) begin
                        err_q <= 1'b1;
                        state <= S_DONE;
                    end else if (wr_done) begin
                        count <= count + LEN_W'(nbytes);
                        if (more_after) begin
                            waddr  <= waddr + ADDR_W'(WORD_BYTES);
                            lane   <= '0;
                            nbytes <= '0;
                            state  <= S_FILL;
                        end else begin
                            state <= S_DONE;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // drive the outputs and the lane buffer controls
    always_comb begin
        busy       = (state != S_IDLE);
        done       = (state == S_DONE);
        err        = err_q;
        byte_count = count;
        in_ready   = (state == S_FILL);
        wr_req     = (state == S_ISSUE);
        wr_addr    = waddr;
        buf_preset = accept_start ||
                     ((state == S_ISSUE) && wr_done && !wr_fail && more_after);
        buf_we     = take;
        buf_lane   = lane;
    end
endmodule

// File: rtl/wpack_top.sv
// Module: unaligned byte-to-word write packer (top).
// Packs a byte stream that starts at any byte address into aligned 32-bit
// program requests, padding unused lanes with 0xFF. Assumes the word
// programmer answers every request with exactly one done or fail pulse.
module wpack_top
    import wpack_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LEN_W  = 16,
    localparam int LANE_W = $clog2(WORD_BYTES),
    localparam int DATA_W = WORD_BYTES * 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [ADDR_W-1:0]  start_addr,
    input  logic [LEN_W-1:0]   length,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic [LEN_W-1:0]   byte_count,
    input  logic               in_valid,
    input  logic [7:0]         in_data,
    output logic               in_ready,
    output logic               wr_req,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [DATA_W-1:0]  wr_data,
    input  logic               wr_done,
    input  logic               wr_fail
);
    logic              buf_preset;
    logic              buf_we;
    logic [LANE_W-1:0] buf_lane;

    wpack_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_addr (start_addr),
        .length     (length),
        .in_valid   (in_valid),
        .wr_done    (wr_done),
        .wr_fail    (wr_fail),
        .busy       (busy),
        .done       (done),
        .err        (err),
        .byte_count (byte_count),
        .in_ready   (in_ready),
        .wr_req     (wr_req),
        .wr_addr    (wr_addr),
        .buf_preset (buf_preset),
        .buf_we     (buf_we),
        .buf_lane   (buf_lane)
    );

    wpack_lane_buf #(.NLANES(WORD_BYTES)) lanes_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .preset (buf_preset),
        .wr_en  (buf_we),
        .lane   (buf_lane),
        .din    (in_data),
        .word   (wr_data)
    );
endmodule

// File: rtl/wpack_top_chk.sv
// Module: protocol checker for wpack_top, bound to every instance.
// Only observes the top-level ports.
module wpack_top_chk #(
    parameter int ADDR_W = 24,
    parameter int LEN_W  = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ADDR_W-1:0] start_addr,
    input logic [LEN_W-1:0]  length,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic [LEN_W-1:0]  byte_count,
    input logic              in_valid,
    input logic [7:0]        in_data,
    input logic              in_ready,
    input logic              wr_req,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_done,
    input logic              wr_fail
);
    // R1
    word_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (wr_addr[1:0] == 2'b00));

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_done && !wr_fail) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

    // R10
    ready_req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_req && in_ready));

    // R6
    empty_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && length == '0) |=> (done && !wr_req && !in_ready));

    // R8
    fail_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_fail) |=> (done && err && !wr_req));

    // R7
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_req && wr_done) && !(start && !busy)) |=> $stable(byte_count));
endmodule

bind wpack_top wpack_top_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/wpack_top_tb_top.sv
`timescale 1ns/1ps
module wpack_top_tb_top;
    localparam int ADDR_W = 24;
    localparam int LEN_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic [LEN_W-1:0]  length = '0;
    logic              busy, done, err;
    logic [LEN_W-1:0]  byte_count;
    logic              in_valid = 1'b0;
    logic [7:0]        in_data = '0;
    logic              in_ready;
    logic              wr_req;
    logic [ADDR_W-1:0] wr_addr;
    logic [31:0]       wr_data;
    logic              wr_done = 1'b0;
    logic              wr_fail = 1'b0;

    always #2.5 clk = ~clk;

    wpack_top #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) dut_i (.*);

    typedef struct {
        logic [ADDR_W-1:0] addr;
        logic [31:0]       data;
        int                prev;
        int                nb;
        bit                fail;
        int                tag;
    } exp_word_t;

    exp_word_t   exp_q[$];
    logic [7:0]  pay[64];
    int          checks = 0;
    int          errors = 0;
    int          words_seen = 0;
    logic [31:0] first_data = '0;
    bit          summary_done = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // scoreboard monitor: plays the word programmer and compares each request
    initial begin
        forever begin
            @(negedge clk);
            if (wr_req) begin
                chk(in_ready == 1'b0, "R10", in_ready, 0);
                chk(wr_addr[1:0] == 2'b00, "R1", wr_addr, wr_addr & ~24'h3);
                if (exp_q.size() == 0) begin
                    chk(0, "R8", wr_addr, 0);
                    wr_done = 1'b1;
                    @(negedge clk);
                    wr_done = 1'b0;
                end else begin
                    exp_word_t e;
                    int lat;
                    e = exp_q.pop_front();
                    if (words_seen == 0) first_data = wr_data;
                    chk(wr_addr == e.addr, $sformatf("R%0d addr", e.tag), wr_addr, e.addr);
                    chk(wr_data == e.data, $sformatf("R%0d data", e.tag), wr_data, e.data);
                    lat = 1 + (words_seen % 3);
                    repeat (lat - 1) @(negedge clk);
                    if (e.fail) wr_fail = 1'b1;
                    else        wr_done = 1'b1;
                    @(negedge clk);
                    wr_done = 1'b0;
                    wr_fail = 1'b0;
                    words_seen++;
                    if (e.fail)
                        chk(byte_count == LEN_W'(e.prev), "R8 count", byte_count, e.prev);
                    else
                        chk(byte_count == LEN_W'(e.prev + e.nb), "R7", byte_count, e.prev + e.nb);
                end
            end
        end
    end

    // driver: computes the expected words, starts a transfer, feeds bytes
    task automatic run_xfer(input int addr, input int len, input int fidx, input bit gaps);
        int off, lane, nb, cum, wi, nwords, exp_cnt, issued, i, cyc;
        logic [31:0] w;
        bit first, took, fin;
        off = addr % 4; lane = off; nb = 0; cum = 0; wi = 0; first = 1;
        w = 32'hFFFF_FFFF; exp_cnt = 0;
        exp_q.delete();
        for (int k = 0; k < len; k++) begin
            w[lane*8 +: 8] = pay[k];
            lane++; nb++;
            if (lane == 4 || k == len - 1) begin
                exp_word_t e;
                e.addr = ADDR_W'((addr & ~3) + 4 * wi);
                e.data = w;
                e.prev = cum;
                e.nb   = nb;
                e.fail = (wi == fidx);
                if (first && off != 0) e.tag = (lane < 4) ? 3 : 2;
                else                   e.tag = (lane < 4) ? 5 : 4;
                exp_q.push_back(e);
                if (fidx < 0 || wi < fidx) exp_cnt = cum + nb;
                cum += nb; wi++; first = 0; lane = 0; nb = 0; w = 32'hFFFF_FFFF;
            end
        end
        nwords = wi;
        issued = (fidx >= 0 && fidx < nwords) ? fidx + 1 : nwords;
        words_seen = 0;
        @(negedge clk);
        start = 1'b1; start_addr = ADDR_W'(addr); length = LEN_W'(len);
        @(negedge clk);
        start = 1'b0;
        i = 0; cyc = 0; took = 0; fin = 0;
        while (!fin && cyc < 3000) begin
            if (took) i++;
            if (done) begin
                fin = 1; in_valid = 1'b0; took = 0;
            end else begin
                if (i < len) begin
                    in_valid = gaps ? ((cyc % 3) != 1) : 1'b1;
                    in_data  = pay[i];
                    took     = in_valid && in_ready;
                end else begin
                    in_valid = 1'b0; took = 0;
                end
                @(negedge clk);
                cyc++;
            end
        end
        chk(fin, "R8 done seen", fin, 1);
        if (len == 0) chk(cyc == 0, "R6 done latency", cyc, 0);
        chk(words_seen == issued, "R8 words issued", words_seen, issued);
        chk(err == (issued != nwords || (fidx >= 0 && fidx < nwords)), "R8 err",
            err, (fidx >= 0 && fidx < nwords));
        chk(byte_count == LEN_W'(exp_cnt), "R7 final count", byte_count, exp_cnt);
        exp_q.delete();
        repeat (2) @(negedge clk);
    endtask

    // watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        for (int k = 0; k < 64; k++) pay[k] = 8'(8'h11 * (k % 15 + 1) + k);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !err, "R6 reset idle", {busy, done, err}, 0);
        chk(!wr_req && !in_ready, "R10 reset", {wr_req, in_ready}, 0);
        chk(byte_count == 0, "R7 reset count", byte_count, 0);

        // R9: aligned word, little-endian lanes
        pay[0] = 8'h11; pay[1] = 8'h22; pay[2] = 8'h33; pay[3] = 8'h44;
        run_xfer(32'h100, 4, -1, 0);
        chk(first_data == 32'h4433_2211, "R9", first_data, 32'h4433_2211);

        for (int k = 0; k < 64; k++) pay[k] = 8'(8'h5A ^ (k * 13));
        // R2, R4, R5: head of 3, one whole word, tail of 3
        run_xfer(32'h201, 10, -1, 0);
        // R3: head runs out at lane 2
        run_xfer(32'h302, 1, -1, 0);
        chk(first_data == {8'hFF, pay[0], 16'hFFFF}, "R3 lane", first_data, {8'hFF, pay[0], 16'hFFFF});
        // R5: aligned with tail of 2
        run_xfer(32'h400, 6, -1, 1);
        // R6: zero length
        run_xfer(32'h503, 0, -1, 0);
        chk(words_seen == 0, "R6 no request", words_seen, 0);
        // R8: failure on the second word
        run_xfer(32'h603, 12, 1, 0);
        // R8: failure on the first word
        run_xfer(32'h700, 8, 0, 1);
        // R4, R7: long transfer with gaps in the stream
        run_xfer(32'h802, 40, -1, 1);
        finish_run();
    end
endmodule